// File: doc/BRIEF.md
# Two-Tier Buffer Pool Allocator

This block supplies packet-buffer handles to a receive path that has to refill an empty ring slot. Each interface owns a private set of handles whose size is fixed when the block comes out of reset and never grows. When that private set runs dry, a request is served from a shared public set. When both sets are exhausted, the request is refused and the block mutes the interface for a programmable number of cycles.

Every handle carries a one-bit origin tag. When the consumer gives a handle back, it presents that tag, and the handle is queued on the set it originally came from. Two saturating event counters record how often the shared set had to step in and how many requests were refused. A synchronous clear input zeroes both counters.

Top module: `bufpool_alloc`

## Requirements
- R1: After reset the private set holds handle indices 0 to PRIV_N-1 and the public set holds 0 to PUB_N-1, each queued in ascending order. Both counters read zero, and `throttled`, `gnt` and `drop` are low.
- R2: A request on a cycle where `throttled` is low and the private set is not empty is granted in that same cycle with `gnt_tag`=0 (0 means private). The handle granted is the oldest queued private index.
- R3: A request on a cycle where the private set is empty and the public set is not is granted in that same cycle with `gnt_tag`=1 (1 means public). The handle granted is the oldest queued public index.
- R4: Every grant with `gnt_tag`=1 raises `fb_cnt` by one on the next cycle. Private grants leave it unchanged.
- R5: A request on a cycle where both sets are empty and `throttled` is low raises `drop` in that cycle and keeps `gnt` low. `ign_cnt` rises by one on the next cycle.
- R6: After a drop, `throttled` is high for exactly the number of cycles that `thr_cycles` held in the drop cycle, and then it clears by itself. A value of 0 gives no throttle.
- R7: While `throttled` is high, a request produces neither `gnt` nor `drop`, and neither counter moves.
- R8: A release with `rel_tag`=0 queues `rel_idx` at the tail of the private set. A release with `rel_tag`=1 queues it at the tail of the public set. Releases are accepted during throttle.
- R9: A request and a release in the same cycle are both carried out. The released handle can be granted from the following cycle onward, but not in the cycle of its release.
- R10: Each counter stops at 2^CNT_W-1 and does not wrap.
- R11: `clr_cnt` high zeroes both counters on the next cycle. It takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_cnt | input | 1 | Synchronous clear of both counters |
| thr_cycles | input | THR_W | Throttle length in cycles, sampled on a drop |
| req | input | 1 | Request for a buffer handle |
| gnt | output | 1 | Request granted this cycle |
| gnt_tag | output | 1 | Origin of the granted handle: 0 private, 1 public |
| gnt_idx | output | IW | Granted handle index |
| drop | output | 1 | Request refused because both sets are empty |
| rel | input | 1 | Handle release |
| rel_tag | input | 1 | Origin tag of the released handle |
| rel_idx | input | IW | Released handle index |
| throttled | output | 1 | Interface muted after a drop |
| fb_cnt | output | CNT_W | Saturating count of public-set grants |
| ign_cnt | output | CNT_W | Saturating count of drops |

## Verification
The bench builds the block with PRIV_N=2, PUB_N=3, CNT_W=3 and THR_W=4. With these values both sets can be drained in five requests, so fallback, exhaustion and refill are reached within a few cycles of one another. The 3-bit counters make the saturation point of 7 reachable with a short burst of drops at zero throttle length. A throttle length of 3 is short enough to probe the first cycle, the last cycle and the first free cycle of the window individually.

// File: rtl/bufpool_alloc.sv
module bufpool_alloc #(
  parameter int PRIV_N = 4,
  parameter int PUB_N  = 8,
  parameter int CNT_W  = 16,
  parameter int THR_W  = 12,
  localparam int MAXN  = (PRIV_N > PUB_N) ? PRIV_N : PUB_N,
  localparam int IW    = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_cnt,
  input  logic [THR_W-1:0] thr_cycles,
  input  logic             req,
  output logic             gnt,
  output logic             gnt_tag,
  output logic [IW-1:0]    gnt_idx,
  output logic             drop,
  input  logic             rel,
  input  logic             rel_tag,
  input  logic [IW-1:0]    rel_idx,
  output logic             throttled,
  output logic [CNT_W-1:0] fb_cnt,
  output logic [CNT_W-1:0] ign_cnt
);
  localparam int PCW = $clog2(PRIV_N + 1);
  localparam int UCW = $clog2(PUB_N + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [IW-1:0]    priv_mem [PRIV_N];
  logic [IW-1:0]    pub_mem  [PUB_N];
  logic [IW-1:0]    priv_rd, priv_wr, pub_rd, pub_wr;
  logic [PCW-1:0]   priv_cnt;
  logic [UCW-1:0]   pub_cnt;
  logic [THR_W-1:0] thr_cnt;

  logic priv_has, pub_has, priv_pop, pub_pop, priv_push, pub_push;

  assign priv_has  = priv_cnt != '0;
  assign pub_has   = pub_cnt != '0;
  assign throttled = thr_cnt != '0;
  assign gnt       = req & ~throttled & (priv_has | pub_has);
  assign drop      = req & ~throttled & ~priv_has & ~pub_has;
  assign gnt_tag   = ~priv_has;
  assign gnt_idx   = priv_has ? priv_mem[priv_rd] : pub_mem[pub_rd];
  assign priv_pop  = gnt & priv_has;
  assign pub_pop   = gnt & ~priv_has;
  assign priv_push = rel & ~rel_tag & (priv_cnt != PCW'(PRIV_N));
  assign pub_push  = rel & rel_tag & (pub_cnt != UCW'(PUB_N));

  function automatic logic [IW-1:0] wrap(input logic [IW-1:0] p, input int n);
    return (int'(p) == n - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PRIV_N; i++) priv_mem[i] <= IW'(i);
      priv_rd  <= '0;
      priv_wr  <= '0;
      priv_cnt <= PCW'(PRIV_N);
    end else begin
      if (priv_push) begin
        priv_mem[priv_wr] <= rel_idx;
        priv_wr <= wrap(priv_wr, PRIV_N);
      end
      if (priv_pop) priv_rd <= wrap(priv_rd, PRIV_N);
      if (priv_push && !priv_pop)      priv_cnt <= priv_cnt + 1'b1;
      else if (!priv_push && priv_pop) priv_cnt <= priv_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PUB_N; i++) pub_mem[i] <= IW'(i);
      pub_rd  <= '0;
      pub_wr  <= '0;
      pub_cnt <= UCW'(PUB_N);
    end else begin
      if (pub_push) begin
        pub_mem[pub_wr] <= rel_idx;
        pub_wr <= wrap(pub_wr, PUB_N);
      end
      if (pub_pop) pub_rd <= wrap(pub_rd, PUB_N);
      if (pub_push && !pub_pop)      pub_cnt <= pub_cnt + 1'b1;
      else if (!pub_push && pub_pop) pub_cnt <= pub_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         thr_cnt <= '0;
    else if (drop)      thr_cnt <= thr_cycles;
    else if (throttled) thr_cnt <= thr_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_cnt) begin
      fb_cnt  <= '0;
      ign_cnt <= '0;
    end else begin
      if (pub_pop && fb_cnt != CMAX) fb_cnt  <= fb_cnt + 1'b1;
      if (drop && ign_cnt != CMAX)   ign_cnt <= ign_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bufpool_alloc_chk.sv
module bufpool_alloc_chk #(
  parameter int CNT_W = 16,
  parameter int THR_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_cnt,
  input logic [THR_W-1:0] thr_cycles,
  input logic             gnt,
  input logic             gnt_tag,
  input logic             drop,
  input logic             throttled,
  input logic [CNT_W-1:0] fb_cnt,
  input logic [CNT_W-1:0] ign_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_GNT_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gnt && drop)); // R5
  AST_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) throttled |-> (!gnt && !drop)); // R7
  AST_DROP_THROTTLES: assert property (@(posedge clk) disable iff (!rst_n) (drop && thr_cycles != '0) |=> throttled); // R6
  AST_ZERO_NO_THROTTLE: assert property (@(posedge clk) disable iff (!rst_n) (drop && thr_cycles == '0) |=> !throttled); // R6
  AST_FB_STEP: assert property (@(posedge clk) disable iff (!rst_n) (gnt && gnt_tag && !clr_cnt && fb_cnt != CMAX) |=> fb_cnt == $past(fb_cnt) + 1'b1); // R4
  AST_IGN_STEP: assert property (@(posedge clk) disable iff (!rst_n) (drop && !clr_cnt && ign_cnt != CMAX) |=> ign_cnt == $past(ign_cnt) + 1'b1); // R5
  AST_IGN_SAT: assert property (@(posedge clk) disable iff (!rst_n) (ign_cnt == CMAX && !clr_cnt) |=> ign_cnt == CMAX); // R10
  AST_FB_SAT: assert property (@(posedge clk) disable iff (!rst_n) (fb_cnt == CMAX && !clr_cnt) |=> fb_cnt == CMAX); // R10
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr_cnt |=> (fb_cnt == '0 && ign_cnt == '0)); // R11
endmodule

bind bufpool_alloc bufpool_alloc_chk #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .thr_cycles(thr_cycles),
  .gnt(gnt), .gnt_tag(gnt_tag), .drop(drop), .throttled(throttled),
  .fb_cnt(fb_cnt), .ign_cnt(ign_cnt)
);

// File: tb/test_bufpool_alloc.sv
module test_bufpool_alloc;
  localparam int PRIV_N = 2;
  localparam int PUB_N  = 3;
  localparam int CNT_W  = 3;
  localparam int THR_W  = 4;
  localparam int IW     = 2;

  logic clk = 1'b0, rst_n = 1'b0, clr_cnt = 1'b0;
  logic [THR_W-1:0] thr_cycles = '0;
  logic req = 1'b0, rel = 1'b0, rel_tag = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic gnt, gnt_tag, drop, throttled;
  logic [IW-1:0] gnt_idx;
  logic [CNT_W-1:0] fb_cnt, ign_cnt;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bufpool_alloc #(.PRIV_N(PRIV_N), .PUB_N(PUB_N), .CNT_W(CNT_W), .THR_W(THR_W)) i_bufpool_alloc (
    .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .thr_cycles(thr_cycles),
    .req(req), .gnt(gnt), .gnt_tag(gnt_tag), .gnt_idx(gnt_idx), .drop(drop),
    .rel(rel), .rel_tag(rel_tag), .rel_idx(rel_idx), .throttled(throttled),
    .fb_cnt(fb_cnt), .ign_cnt(ign_cnt)
  );

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic drive(bit r, bit rl, bit rt, int ri);
    @(negedge clk);
    req = r; rel = rl; rel_tag = rt; rel_idx = IW'(ri);
    #1;
  endtask

  task automatic expect_gnt(string rq, int tag, int idx);
    chk({rq, " gnt"}, int'(gnt), 1);
    chk({rq, " tag"}, int'(gnt_tag), tag);
    chk({rq, " idx"}, int'(gnt_idx), idx);
  endtask

  task automatic t_reset();
    drive(0, 0, 0, 0);
    chk("R1 gnt", int'(gnt), 0);
    chk("R1 drop", int'(drop), 0);
    chk("R1 throttled", int'(throttled), 0);
    chk("R1 fb_cnt", int'(fb_cnt), 0);
    chk("R1 ign_cnt", int'(ign_cnt), 0);
  endtask

  task automatic t_fallback();
    drive(1, 0, 0, 0); expect_gnt("R2 R1 first private", 0, 0);
    drive(1, 0, 0, 0); expect_gnt("R2 R1 second private", 0, 1);
    drive(1, 0, 0, 0); expect_gnt("R3 R1 first public", 1, 0);
    drive(1, 0, 0, 0); expect_gnt("R3 R1 second public", 1, 1);
    chk("R4 fb after one public", int'(fb_cnt), 1);
    drive(1, 0, 0, 0); expect_gnt("R3 R1 third public", 1, 2);
    drive(0, 0, 0, 0);
    chk("R4 fb_cnt", int'(fb_cnt), 3);
    chk("R4 ign_cnt", int'(ign_cnt), 0);
  endtask

  task automatic t_throttle();
    thr_cycles = 4'd3;
    drive(1, 0, 0, 0);
    chk("R5 drop", int'(drop), 1);
    chk("R5 no gnt", int'(gnt), 0);
    drive(1, 1, 0, 1);
    chk("R6 throttle cycle1", int'(throttled), 1);
    chk("R7 no gnt", int'(gnt), 0);
    chk("R7 no drop", int'(drop), 0);
    chk("R5 ign_cnt", int'(ign_cnt), 1);
    drive(1, 0, 0, 0);
    chk("R6 throttle cycle2", int'(throttled), 1);
    chk("R7 no gnt cycle2", int'(gnt), 0);
    drive(1, 0, 0, 0);
    chk("R6 throttle cycle3", int'(throttled), 1);
    chk("R7 no drop cycle3", int'(drop), 0);
    drive(1, 0, 0, 0);
    chk("R6 throttle over", int'(throttled), 0);
    expect_gnt("R8 released during throttle", 0, 1);
    drive(0, 0, 0, 0);
    chk("R7 ign_cnt unchanged", int'(ign_cnt), 1);
    chk("R7 fb_cnt unchanged", int'(fb_cnt), 3);
  endtask

  task automatic t_return();
    drive(0, 1, 1, 2);
    drive(0, 1, 0, 0);
    drive(1, 0, 0, 0); expect_gnt("R2 private preferred", 0, 0);
    drive(1, 0, 0, 0); expect_gnt("R8 public return", 1, 2);
    drive(0, 0, 0, 0);
    chk("R4 fb_cnt after return", int'(fb_cnt), 4);
  endtask

  task automatic t_same_cycle();
    drive(0, 1, 1, 0);
    drive(1, 1, 0, 1); expect_gnt("R9 same-cycle grant", 1, 0);
    drive(1, 0, 0, 0); expect_gnt("R9 released next cycle", 0, 1);
    drive(0, 0, 0, 0);
    chk("R4 fb_cnt same-cycle", int'(fb_cnt), 5);
  endtask

  task automatic t_saturate();
    thr_cycles = 4'd0;
    for (int i = 0; i < 8; i++) begin
      drive(1, 0, 0, 0);
      chk("R5 repeated drop", int'(drop), 1);
      chk("R6 zero length", int'(throttled), 0);
    end
    drive(0, 0, 0, 0);
    chk("R10 ign_cnt saturated", int'(ign_cnt), 7);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr_cnt = 1'b1;
    drive(1, 0, 0, 0);
    chk("R11 drop during clear", int'(drop), 1);
    @(negedge clk);
    clr_cnt = 1'b0;
    req = 1'b0;
    #1;
    chk("R11 fb_cnt cleared", int'(fb_cnt), 0);
    chk("R11 ign_cnt cleared", int'(ign_cnt), 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    chk("R11 counting resumes", int'(ign_cnt), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fallback();
    t_throttle();
    t_return();
    t_same_cycle();
    t_saturate();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule